// File: doc/BRIEF.md
# Monochrome Balanced TMDS Pair Encoder

This block turns packed one-bit-per-pixel black/white image data into 10-bit TMDS symbols for one channel, at full resolution. It does not run the general transition-minimising encode. Each pixel gets one of four fixed codewords, picked by its colour bit and by whether its x position is even or odd.

The even-slot codeword always moves the running balance to -8. The odd-slot codeword always brings it back to 0. Every even/odd pair is therefore DC balanced on its own, and no disparity counter is kept. Output counts are always even.

A pixel word enters on a valid/ready handshake and is held while it is spent as a sequence of output pairs, one pair per accepted output beat. Each beat carries two symbols packed into 20 bits. A parameter chooses whether the lowest or the highest bit of the word is the first pixel on screen.

Top module: `tmds_mono_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `out_valid` low and `in_ready` high, discards any held word, and makes the next accepted word start from its first pair.
- R2: Bits [9:0] of `out_data` hold the even-x pixel symbol: 10'h100 for a black pixel (bit value 0) and 10'h200 for a white pixel (bit value 1).
- R3: Bits [19:10] of `out_data` hold the odd-x pixel symbol: 10'h1FF for black (0) and 10'h2FF for white (1). Two black pixels therefore give 20'h7FD00.
- R4: With `LSB_FIRST`=1, pair j of a word takes word bit 2j as its even pixel and bit 2j+1 as its odd pixel. With `LSB_FIRST`=0, it takes bit WORD_W-1-2j as the even pixel and bit WORD_W-2-2j as the odd pixel.
- R5: An accepted word yields WORD_W/2 output pairs, one per accepted output beat, in increasing pair order. After the last pair the block takes the next word.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change at the next edge.
- R7: `in_ready` is high when no word is held, or when the last pair of the held word is being accepted in the same cycle; otherwise it is low.
- R8: Every valid output beat contains exactly ten 1 bits over its 20 bits, so each pair has zero net disparity.
- R9: A word accepted in the same cycle as the previous word's last pair is presented on the very next cycle, with no idle beat between the two words.
- R10: `in_valid` and `in_data` have no effect while `in_ready` is low: the held word's remaining pairs are unchanged, and no extra word appears after them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel word offered |
| in_ready | output | 1 | Encoder can take a pixel word this cycle |
| in_data | input | WORD_W | Packed 1-bit pixels |
| out_valid | output | 1 | Symbol pair available |
| out_ready | input | 1 | Sink takes the symbol pair this cycle |
| out_data | output | 20 | Odd-x symbol in [19:10], even-x symbol in [9:0] |

## Verification
The hardest case to reach is the seam between two words, where the last pair is consumed and the next word is loaded on the same edge. Reaching it needs `in_valid` raised in exactly the cycle in which the final pair is presented with `out_ready` high. The bench drains a word pair by pair, raises `in_valid` only at the sixteenth pair, and then expects the new word's first pair on the following cycle.

A second seam is the case where input is offered while the encoder is busy. The bench offers a different word during an output stall and then confirms that the held word finishes unchanged and nothing follows it. Both pixel orderings run in parallel, on two instances driven by the same stimulus.

// File: rtl/tmds_mono_pkg.sv
package tmds_mono_pkg;

    localparam int SYM_W  = 10;
    localparam int PAIR_W = 2 * SYM_W;

    // Fixed codebook: even slot lands at balance -8, odd slot returns to 0.
    localparam logic [SYM_W-1:0] SYM_EVEN_DARK  = 10'h100;
    localparam logic [SYM_W-1:0] SYM_EVEN_LIGHT = 10'h200;
    localparam logic [SYM_W-1:0] SYM_ODD_DARK   = 10'h1FF;
    localparam logic [SYM_W-1:0] SYM_ODD_LIGHT  = 10'h2FF;

    typedef struct packed {
        logic odd_px;
        logic even_px;
    } px_pair_t;

endpackage

// File: rtl/tmds_mono_bit_pick.sv
module tmds_mono_bit_pick
    import tmds_mono_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic [WORD_W-1:0]          word,
    input  logic [$clog2(WORD_W)-2:0]  pair_idx,
    output px_pair_t                   pair
);

    localparam int POS_W = $clog2(WORD_W);

    logic [POS_W-1:0] pos_even;
    logic [POS_W-1:0] pos_odd;

    assign pos_even = {pair_idx, 1'b0};
    assign pos_odd  = {pair_idx, 1'b1};

    generate
        if (LSB_FIRST) begin : g_lsb_first
            assign pair.even_px = word[pos_even];
            assign pair.odd_px  = word[pos_odd];
        end else begin : g_msb_first
            logic [POS_W-1:0] top_pos;
            assign top_pos      = POS_W'(WORD_W - 1);
            assign pair.even_px = word[top_pos - pos_even];
            assign pair.odd_px  = word[top_pos - pos_odd];
        end
    endgenerate

endmodule

// File: rtl/tmds_mono_pair_lut.sv
module tmds_mono_pair_lut
    import tmds_mono_pkg::*;
(
    input  px_pair_t           pair,
    output logic [PAIR_W-1:0]  symbols
);

    localparam logic [1:0][SYM_W-1:0] DARK_CODES  = {SYM_ODD_DARK,  SYM_EVEN_DARK};
    localparam logic [1:0][SYM_W-1:0] LIGHT_CODES = {SYM_ODD_LIGHT, SYM_EVEN_LIGHT};

    logic [1:0] px_bits;
    assign px_bits = {pair.odd_px, pair.even_px};

    generate
        for (genvar s = 0; s < 2; s++) begin : g_slot
            assign symbols[s*SYM_W +: SYM_W] = px_bits[s] ? LIGHT_CODES[s] : DARK_CODES[s];
        end
    endgenerate

endmodule

// File: rtl/tmds_mono_encoder.sv
module tmds_mono_encoder
    import tmds_mono_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [19:0]       out_data
);

    localparam int PAIRS = WORD_W / 2;
    localparam int IDX_W = $clog2(PAIRS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAIRS - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              busy;
        logic [IDX_W-1:0]  idx;
    } state_t;

    state_t   st_d, st_q;
    logic     pop, last_pair, take;
    px_pair_t cur_pair;

    always_comb begin
        st_d      = st_q;
        last_pair = (st_q.idx == LAST_IDX);
        pop       = st_q.busy && out_ready;
        in_ready  = !st_q.busy || (out_ready && last_pair);
        take      = in_valid && in_ready;

        if (pop) begin
            if (last_pair) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx  = st_q.idx + 1'b1;
            end
        end

        if (take) begin
            st_d.word = in_data;
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end

        if (rst) begin
            st_d.word = '0;
            st_d.busy = 1'b0;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    tmds_mono_bit_pick #(
        .WORD_W    (WORD_W),
        .LSB_FIRST (LSB_FIRST)
    ) u_pick (
        .word     (st_q.word),
        .pair_idx (st_q.idx),
        .pair     (cur_pair)
    );

    tmds_mono_pair_lut u_lut (
        .pair    (cur_pair),
        .symbols (out_data)
    );

    assign out_valid = st_q.busy;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !out_valid && in_ready); // R1

    AST_EVEN_SLOT_FORM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[7:0] == 8'h00) && (out_data[9] != out_data[8])); // R2

    AST_ODD_SLOT_FORM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[17:10] == 8'hFF) && (out_data[19] != out_data[18])); // R3

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready); // R7

    AST_PAIR_BALANCE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_data) == 10)); // R8

    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R9

endmodule

// File: tb/tb_tmds_mono_encoder.sv
module tb_tmds_mono_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 32;
    localparam int PAIRS      = WORD_W / 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [WORD_W-1:0] in_data;
    logic              out_ready;
    logic              in_ready, in_ready_rev;
    logic              out_valid, out_valid_rev;
    logic [19:0]       out_data, out_data_rev;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmds_mono_encoder #(.WORD_W(WORD_W), .LSB_FIRST(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data));

    tmds_mono_encoder #(.WORD_W(WORD_W), .LSB_FIRST(1'b0)) dut_rev (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_rev),
        .in_data(in_data), .out_valid(out_valid_rev), .out_ready(out_ready),
        .out_data(out_data_rev));

    function automatic logic [19:0] exp_pair(logic [WORD_W-1:0] w, int j, bit msb);
        logic e, o;
        e = msb ? w[WORD_W-1-2*j] : w[2*j];
        o = msb ? w[WORD_W-2-2*j] : w[2*j+1];
        return {(o ? 10'h2FF : 10'h1FF), (e ? 10'h200 : 10'h100)};
    endfunction

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_word(logic [WORD_W-1:0] w);
        in_valid = 1'b1;
        in_data  = w;
        tick();
        in_valid = 1'b0;
    endtask

    // Consume pairs first..lastp of w, checking both orderings and the ready rule.
    task automatic drain(logic [WORD_W-1:0] w, int first, int lastp);
        out_ready = 1'b1;
        for (int j = first; j <= lastp; j++) begin
            check_eq("R5 valid",       32'(out_valid), 32'd1);
            check_eq("R2/R3 lsb pair", 32'(out_data), 32'(exp_pair(w, j, 1'b0)));
            check_eq("R4 msb pair",    32'(out_data_rev), 32'(exp_pair(w, j, 1'b1)));
            check_eq("R8 ones",        32'($countones(out_data)), 32'd10);
            check_eq("R7 ready",       32'(in_ready), (j == PAIRS-1) ? 32'd1 : 32'd0);
            tick();
        end
        out_ready = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        tick(); tick();
        rst = 1'b0;
        check_eq("R1 out_valid", 32'(out_valid), 32'd0);
        check_eq("R1 in_ready",  32'(in_ready),  32'd1);
    endtask

    task automatic test_all_black();
        load_word('0);
        check_eq("R3 black pair", 32'(out_data), 32'h7FD00);
        drain('0, 0, PAIRS-1);
        check_eq("R5 idle after word", 32'(out_valid), 32'd0);
    endtask

    task automatic test_patterns();
        logic [WORD_W-1:0] pats [3];
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'hA5C3_0F96;
        pats[2] = 32'h1234_8001;
        for (int p = 0; p < 3; p++) begin
            load_word(pats[p]);
            drain(pats[p], 0, PAIRS-1);
        end
        check_eq("R2 white even", 32'(exp_pair(32'hFFFF_FFFF, 0, 1'b0)), 32'hBFE00);
    endtask

    task automatic test_stall_and_ignore();
        logic [WORD_W-1:0] w = 32'h6B1D_E247;
        logic [19:0] held;
        load_word(w);
        drain(w, 0, 4);
        held = out_data;
        in_valid = 1'b1;
        in_data  = 32'hFFFF_0000;
        for (int k = 0; k < 3; k++) begin
            tick();
            check_eq("R6 valid held", 32'(out_valid), 32'd1);
            check_eq("R6 data held",  32'(out_data), 32'(held));
            check_eq("R10 not ready", 32'(in_ready), 32'd0);
        end
        in_valid = 1'b0;
        drain(w, 5, PAIRS-1);
        check_eq("R10 no extra word", 32'(out_valid), 32'd0);
    endtask

    task automatic test_back_to_back();
        logic [WORD_W-1:0] w1 = 32'h0F0F_3C3C;
        logic [WORD_W-1:0] w2 = 32'hC001_D00D;
        load_word(w1);
        drain(w1, 0, PAIRS-2);
        out_ready = 1'b1;
        check_eq("R7 ready at last", 32'(in_ready), 32'd1);
        check_eq("R5 last pair", 32'(out_data), 32'(exp_pair(w1, PAIRS-1, 1'b0)));
        in_valid = 1'b1;
        in_data  = w2;
        tick();
        in_valid = 1'b0;
        check_eq("R9 no bubble", 32'(out_valid), 32'd1);
        drain(w2, 0, PAIRS-1);
    endtask

    task automatic test_mid_reset();
        logic [WORD_W-1:0] w = 32'h8421_7BDE;
        load_word(32'h5555_AAAA);
        drain(32'h5555_AAAA, 0, 6);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check_eq("R1 reset drops word", 32'(out_valid), 32'd0);
        check_eq("R1 ready after reset", 32'(in_ready), 32'd1);
        load_word(w);
        drain(w, 0, PAIRS-1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R5: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_all_black();
        test_patterns();
        test_stall_and_ignore();
        test_back_to_back();
        test_mid_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule